// File: doc/BRIEF.md
# Codec Register Configuration Sequencer

After reset this block writes a fixed list of ten register settings into an audio codec over a two-wire serial bus. Each write starts with a start condition. Three bytes follow: the device address, the register address and the register data. The slave must acknowledge each byte. The block drives both bus lines open-drain: an output enable pulls a line low, and a cleared enable lets the external pull-up take the line high. No stop condition is ever sent. Once one write is complete, the next write begins directly with a new start condition.

Every bus bit takes three equal phases of `PHASE_CLKS` system clocks. The slave has two deadlines after each byte. It must pull SDA low within one phase. After the acknowledge clock pulse, it must release SDA within `ACK_WINDOW` clocks. If the slave misses either deadline, the block raises a one-clock error pulse and restarts the whole list from the first entry. When the last entry has been acknowledged, the block raises `done`, holds it, and leaves both lines released.

Top module: `codec_cfg_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, both line enables are 0, and `done` and `error` are 0.
- R2: Each register write starts with a start condition: SDA falls while SCL is high. The address byte 0x34 follows, shifted MSB first with one bit per SCL high pulse.
- R3: After each address byte come the register byte and the data byte, MSB first. The pairs are sent in this order: (0C,02) (0E,03) (00,17) (02,17) (04,79) (06,79) (0A,00) (08,12) (10,A0) (12,01), all hex.
- R4: Each SCL high pulse that carries a data bit or an acknowledge lasts exactly `PHASE_CLKS` clocks. SDA is set up one phase before SCL rises, and SCL is pulled low again one phase after it rises.
- R5: The block releases SDA only while it is holding SCL low. Its own driving therefore never forms a stop condition (SDA rising while SCL is high).
- R6: If SDA is still high at the end of the one-phase acknowledge slot, the block raises `error` and restarts from the first entry with a new start condition and address byte.
- R7: If SDA stays low for `ACK_WINDOW` clocks after the acknowledge pulse ends, the block raises `error` and restarts from the first entry.
- R8: `error` is high for exactly one clock for each failed acknowledge or release.
- R9: When the slave releases SDA after the last data byte, `done` rises and stays high. From the following cycle, both line enables stay 0.
- R10: An acknowledge still counts if it reaches the SDA pin at any point in the acknowledge slot, including late in the slot, after the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sdaIn | input | 1 | Level sensed on the SDA line |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | High once the whole list has been written |
| error | output | 1 | One-clock pulse when a timeout forces a restart |

## Verification
The acknowledge check and the end of the acknowledge slot can fall in the same clock. The block accepts an acknowledge that arrives in the last cycle of the slot, and also one that arrived earlier in the slot and was latched. Any other timing is treated as a missing acknowledge. The bench delays the slave's acknowledge by a fixed number of clocks after the eighth SCL fall. In one run the acknowledge lands late inside the slot and must pass with no error. In another run a single byte's acknowledge lands after the slot has closed. That run must produce exactly one error pulse, followed by a full replay of the list that the scoreboard checks byte for byte.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [3:0] {
    S_START_A,
    S_START_B,
    S_START_C,
    S_BIT_SET,
    S_BIT_HIGH,
    S_BIT_LOW,
    S_ACK_WAIT,
    S_ACK_HIGH,
    S_ACK_LOW,
    S_REL_WAIT,
    S_FAIL,
    S_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       timerClr;
    logic       loadByte;
    logic       shiftBit;
    logic       sclPull;
    logic       sdaPull;
    logic       sdaData;
    logic [1:0] byteSel;
  } seqStrobe_t;

  localparam int CFG_ENTRIES = 10;

  // {register, value} for each list position
  function automatic logic [15:0] cfgWord(input int idx);
    case (idx)
      0:       return 16'h0C02;
      1:       return 16'h0E03;
      2:       return 16'h0017;
      3:       return 16'h0217;
      4:       return 16'h0479;
      5:       return 16'h0679;
      6:       return 16'h0A00;
      7:       return 16'h0812;
      8:       return 16'h10A0;
      9:       return 16'h1201;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/cfgseq_datapath.sv
module cfgseq_datapath
  import cfgseq_pkg::*;
#(
  parameter int         PHASE_CLKS  = 32,
  parameter int         ACK_WINDOW  = 128,
  parameter int         SETTLE_CLKS = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ADDR    = 8'h34,
  parameter int         EW          = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sdaIn,
  input  seqStrobe_t    strb,
  input  logic [EW-1:0] entryIdx,
  output logic          phaseEnd,
  output logic          windowEnd,
  output logic          settled,
  output logic          sdaLine,
  output logic          sclOe,
  output logic          sdaOe
);

  localparam int TW = $clog2(ACK_WINDOW + 1);

  logic [TW-1:0]          timer;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic [7:0]             shreg;
  logic [15:0]            word;
  logic [7:0]             nextByte;

  // phase / window timer, restarted on every state change
  always_ff @(posedge clk) begin
    if (!rstN)              timer <= '0;
    else if (strb.timerClr) timer <= '0;
    else if (timer != '1)   timer <= timer + 1'b1;
  end

  assign phaseEnd  = (timer == TW'(PHASE_CLKS - 1));
  assign windowEnd = (timer == TW'(ACK_WINDOW - 1));
  assign settled   = (timer >= TW'(SETTLE_CLKS));

  // input synchronizer
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) sdaPipe <= '1;
        else       sdaPipe <= sdaIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) sdaPipe <= '1;
        else       sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      end
    end
  endgenerate
  assign sdaLine = sdaPipe[SYNC_STAGES-1];

  // byte source selection
  assign word = cfgWord(int'(entryIdx));
  always_comb begin
    case (strb.byteSel)
      2'd0:    nextByte = DEV_ADDR;
      2'd1:    nextByte = word[15:8];
      default: nextByte = word[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              shreg <= '0;
    else if (strb.loadByte) shreg <= nextByte;
    else if (strb.shiftBit) shreg <= {shreg[6:0], 1'b0};
  end

  // registered open-drain enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      sclOe <= strb.sclPull;
      sdaOe <= strb.sdaPull | (strb.sdaData & ~shreg[7]);
    end
  end

  p_release_safe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> sclOe)
    else $error("SDA released while SCL not held low");

  p_timer_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.timerClr |=> (timer == '0))
    else $error("phase timer not restarted");

endmodule

// File: rtl/cfgseq_control.sv
module cfgseq_control
  import cfgseq_pkg::*;
#(
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          phaseEnd,
  input  logic          windowEnd,
  input  logic          settled,
  input  logic          sdaLine,
  output seqStrobe_t    strb,
  output logic [EW-1:0] entryIdx,
  output logic          done,
  output logic          error
);

  seqState_e  state, nxt;
  logic [2:0] bitCnt;
  logic [1:0] byteIdx;
  logic       ackSeen;
  logic       ackNow;
  logic       lastEntry;
  logic       relOk;

  assign ackNow    = settled & ~sdaLine;
  assign relOk     = settled & sdaLine;
  assign lastEntry = (entryIdx == EW'(CFG_ENTRIES - 1));

  always_comb begin
    nxt          = state;
    strb         = '0;
    strb.byteSel = byteIdx;
    case (state)
      S_START_A: if (phaseEnd) nxt = S_START_B;
      S_START_B: begin
        strb.sdaPull = 1'b1;
        if (phaseEnd) nxt = S_START_C;
      end
      S_START_C: begin
        strb.sdaPull = 1'b1;
        strb.sclPull = 1'b1;
        if (phaseEnd) begin
          nxt           = S_BIT_SET;
          strb.loadByte = 1'b1;
        end
      end
      S_BIT_SET: begin
        strb.sclPull = 1'b1;
        strb.sdaData = 1'b1;
        if (phaseEnd) nxt = S_BIT_HIGH;
      end
      S_BIT_HIGH: begin
        strb.sdaData = 1'b1;
        if (phaseEnd) nxt = S_BIT_LOW;
      end
      S_BIT_LOW: begin
        strb.sclPull = 1'b1;
        strb.sdaData = 1'b1;
        if (phaseEnd) begin
          if (bitCnt == 3'd7) nxt = S_ACK_WAIT;
          else begin
            nxt           = S_BIT_SET;
            strb.shiftBit = 1'b1;
          end
        end
      end
      S_ACK_WAIT: begin
        strb.sclPull = 1'b1;
        if (phaseEnd) nxt = (ackSeen | ackNow) ? S_ACK_HIGH : S_FAIL;
      end
      S_ACK_HIGH: if (phaseEnd) nxt = S_ACK_LOW;
      S_ACK_LOW: begin
        strb.sclPull = 1'b1;
        if (phaseEnd) nxt = S_REL_WAIT;
      end
      S_REL_WAIT: begin
        strb.sclPull = 1'b1;
        if (relOk) begin
          if (byteIdx == 2'd2) nxt = lastEntry ? S_DONE : S_START_A;
          else begin
            nxt           = S_BIT_SET;
            strb.loadByte = 1'b1;
            strb.byteSel  = byteIdx + 2'd1;
          end
        end else if (windowEnd) nxt = S_FAIL;
      end
      S_FAIL:  nxt = S_START_A;
      S_DONE:  nxt = S_DONE;
      default: nxt = S_START_A;
    endcase
    strb.timerClr = (nxt != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_START_A;
      bitCnt   <= '0;
      byteIdx  <= '0;
      entryIdx <= '0;
      ackSeen  <= 1'b0;
    end else begin
      state <= nxt;
      if (strb.loadByte)      bitCnt <= '0;
      else if (strb.shiftBit) bitCnt <= bitCnt + 3'd1;
      ackSeen <= (state == S_ACK_WAIT) ? (ackSeen | ackNow) : 1'b0;
      if (state == S_FAIL) begin
        byteIdx  <= '0;
        entryIdx <= '0;
      end else if (state == S_REL_WAIT && relOk) begin
        if (byteIdx == 2'd2) begin
          byteIdx <= '0;
          if (!lastEntry) entryIdx <= entryIdx + 1'b1;
        end else begin
          byteIdx <= byteIdx + 2'd1;
        end
      end
    end
  end

  assign done  = (state == S_DONE);
  assign error = (state == S_FAIL);

  p_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    error |=> (state == S_START_A && entryIdx == '0 && byteIdx == '0))
    else $error("restart did not return to first entry");

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    error |=> !error)
    else $error("error wider than one clock");

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done)
    else $error("done dropped");

  p_window_fail_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REL_WAIT && windowEnd && !relOk) |=> error)
    else $error("release timeout not flagged");

endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import cfgseq_pkg::*;
#(
  parameter int         PHASE_CLKS  = 32,
  parameter int         ACK_WINDOW  = 128,
  parameter int         SETTLE_CLKS = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ADDR    = 8'h34
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdaIn,
  output logic sclOe,
  output logic sdaOe,
  output logic done,
  output logic error
);

  localparam int EW = $clog2(CFG_ENTRIES);

  seqStrobe_t    strb;
  logic [EW-1:0] entryIdx;
  logic          phaseEnd, windowEnd, settled, sdaLine;

  cfgseq_control #(.EW(EW)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .phaseEnd  (phaseEnd),
    .windowEnd (windowEnd),
    .settled   (settled),
    .sdaLine   (sdaLine),
    .strb      (strb),
    .entryIdx  (entryIdx),
    .done      (done),
    .error     (error)
  );

  cfgseq_datapath #(
    .PHASE_CLKS (PHASE_CLKS),
    .ACK_WINDOW (ACK_WINDOW),
    .SETTLE_CLKS(SETTLE_CLKS),
    .SYNC_STAGES(SYNC_STAGES),
    .DEV_ADDR   (DEV_ADDR),
    .EW         (EW)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .sdaIn     (sdaIn),
    .strb      (strb),
    .entryIdx  (entryIdx),
    .phaseEnd  (phaseEnd),
    .windowEnd (windowEnd),
    .settled   (settled),
    .sdaLine   (sdaLine),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe)
  );

  p_idle_lines_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!sclOe && !sdaOe))
    else $error("lines driven after completion");

endmodule

// File: tb/codec_cfg_seq_tb.sv
module codec_cfg_seq_tb_top;

  localparam int PH       = 32;
  localparam int NBYTES   = 30;
  localparam int LATE_ACK = 75;
  localparam int STUCK    = 180;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclOe, sdaOe, done, error;
  logic slavePull = 1'b0;
  logic sclBus, sdaBus;

  always #2 clk = ~clk;

  assign sclBus = ~sclOe;
  assign sdaBus = ~(sdaOe | slavePull);

  codec_cfg_seq dut_i (
    .clk   (clk),
    .rstN  (rstN),
    .sdaIn (sdaBus),
    .sclOe (sclOe),
    .sdaOe (sdaOe),
    .done  (done),
    .error (error)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  // scoreboard entries: pos*256 + byte value
  int expQ[$];
  logic [7:0] regTab[10]  = '{8'h0C, 8'h0E, 8'h00, 8'h02, 8'h04, 8'h06, 8'h0A, 8'h08, 8'h10, 8'h12};
  logic [7:0] dataTab[10] = '{8'h02, 8'h03, 8'h17, 8'h17, 8'h79, 8'h79, 8'h00, 8'h12, 8'hA0, 8'h01};

  // slave / monitor state
  int  bitCnt, pullCnt, holdCnt, recvCount, sclHighLen;
  int  ackDelay, faultKind, faultByte;
  int  errCycles, errEdges;
  bit  stuckPending, startInHigh, stopOk, prevScl, prevSda, prevErr;
  logic [7:0] shreg;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expItem(input int k);
    int e = k / 3;
    int p = k % 3;
    if (p == 0)      return 8'h34;
    else if (p == 1) return 256 + regTab[e];
    else             return 512 + dataTab[e];
  endfunction

  task automatic deliver(input logic [7:0] b);
    int idx = recvCount;
    recvCount++;
    if (expQ.size() == 0) begin
      check(0, "R3 unexpected byte", b, 0);
    end else begin
      int it = expQ.pop_front();
      if (it / 256 == 0) check(b == it[7:0], "R2 address byte", b, it[7:0]);
      else               check(b == it[7:0], "R3 register/data byte", b, it[7:0]);
    end
    pullCnt      = (faultKind == 1 && idx == faultByte) ? LATE_ACK : ackDelay;
    stuckPending = (faultKind == 2 && idx == faultByte);
  endtask

  // bus slave and monitor
  always @(negedge clk) begin
    if (!rstN) begin
      bitCnt = 0; pullCnt = -1; holdCnt = -1; slavePull = 1'b0;
      prevScl = 1; prevSda = 1; prevErr = 0; startInHigh = 1; sclHighLen = 0;
      stuckPending = 0;
    end else begin
      if (error) errCycles++;
      if (error && !prevErr) errEdges++;
      prevErr = error;
      if (pullCnt > 0) pullCnt--;
      else if (pullCnt == 0) begin slavePull = 1'b1; pullCnt = -1; end
      if (holdCnt > 0) holdCnt--;
      else if (holdCnt == 0) begin slavePull = 1'b0; holdCnt = -1; end
      if (sclBus && prevScl && prevSda && !sdaBus) begin
        bitCnt = 0; startInHigh = 1;
      end
      if (sclBus && prevScl && !prevSda && sdaBus && !stopOk)
        check(0, "R5 stop condition seen", 1, 0);
      if (sclBus && !prevScl) begin
        sclHighLen = 0; startInHigh = 0;
        pullCnt = -1;
        if (bitCnt < 8) begin
          shreg = {shreg[6:0], sdaBus};
          bitCnt++;
        end
      end
      if (sclBus) sclHighLen++;
      if (!sclBus && prevScl) begin
        if (!startInHigh) check(sclHighLen == PH, "R4 SCL high width", sclHighLen, PH);
        if (bitCnt == 8) begin
          deliver(shreg);
          bitCnt = 9;
        end else if (bitCnt == 9) begin
          bitCnt = 0;
          if (stuckPending) begin holdCnt = STUCK; stuckPending = 0; end
          else slavePull = 1'b0;
        end
      end
      prevScl = sclBus;
      prevSda = sdaBus;
    end
  end

  task automatic runCase(input int delay, input int kind, input int fbyte,
                         input int expErr, input bit allowStop, input string tag);
    int waitCnt = 0;
    @(negedge clk);
    rstN = 1'b0;
    ackDelay = delay; faultKind = kind; faultByte = fbyte; stopOk = allowStop;
    recvCount = 0; errCycles = 0; errEdges = 0;
    expQ.delete();
    if (kind != 0) for (int k = 0; k <= fbyte; k++) expQ.push_back(expItem(k));
    for (int k = 0; k < NBYTES; k++) expQ.push_back(expItem(k));
    repeat (4) @(negedge clk);
    check(sclOe == 0 && sdaOe == 0, "R1 lines released in reset", {sclOe, sdaOe}, 0);
    check(done == 0 && error == 0, "R1 flags low in reset", {done, error}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sclOe == 0 && sdaOe == 0 && done == 0, "R1 first cycle after reset",
          {sclOe, sdaOe, done}, 0);
    while (!done && waitCnt < 60000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done == 1, {tag, " R9 done reached"}, done, 1);
    check(expQ.size() == 0, {tag, " R3 all bytes seen"}, expQ.size(), 0);
    check(errEdges == expErr, {tag, " error count"}, errEdges, expErr);
    check(errCycles == errEdges, "R8 error one clock wide", errCycles, errEdges);
    repeat (12) @(negedge clk);
    check(done == 1, "R9 done held", done, 1);
    check(sclOe == 0 && sdaOe == 0, "R9 lines released when done", {sclOe, sdaOe}, 0);
    check(sclBus == 1 && sdaBus == 1, "R9 bus idle high", {sclBus, sdaBus}, 3);
  endtask

  initial begin : watchdog
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000 && !finished) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : main
    // R10: acknowledge arriving late inside the slot is still accepted
    runCase(45, 0, 0, 0, 0, "R10 late ack in slot");
    // R6: acknowledge for byte 4 lands after the slot closes
    runCase(0, 1, 4, 1, 0, "R6 missed ack");
    // R7: slave keeps SDA low past the release window on byte 20
    runCase(0, 2, 20, 1, 1, "R7 stuck release");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule